// File: doc/BRIEF.md
# I2C Master Transmit Sequencer

This core drives a two-wire serial bus as a master in transmit direction. Software programs a target address, a byte count and a control word through a small register port. The core then produces the START condition, the address byte with a write flag, the counted data bytes and, when asked, the STOP condition. Both bus lines are open-drain: the core only ever pulls a line low or lets it float high.

The byte count is copied into a hidden down-counter only at the instant a START or repeated START is put on the bus. When that counter runs out and no stop was requested, the core parks the bus with the clock held low and raises a hold flag. Software can then request a repeated START, which reloads the counter from the count register, or request a stop, which is sent at once because nothing is left to transfer. Data bytes come from a one-entry transmit register whose empty state is visible in the status. When that register is empty at a byte boundary, the clock is stretched low until software refills it.

Register map (3-bit address, 8-bit data): 0 = control (bit0 enable, bit1 master, bit2 transmit, bit3 start request, bit4 stop request); 1 = byte count; 2 = 7-bit target address; 3 = transmit data; 4 = status (bit0 hold, bit1 nack, bit2 data register empty, bit3 busy). A write of 1 to status bit0 or bit1 clears that flag.

Top module: `i2c_tx_sequencer`

## Requirements
- R1: From idle, a control write with bits 0 to 3 set makes SDA fall while SCL is high (START), followed by the byte {address, 0} sent MSB first on 8 SCL pulses and a ninth pulse with SDA released for the acknowledge.
- R2: The number of data bytes sent after a START equals the count register value held at the moment that START is generated.
- R3: A write to the count register after a START has been generated does not change the number of bytes sent before the next START.
- R4: When the loaded count is used up without a stop request, status bit0 goes to 1, SCL stays low and no STOP appears on the bus. A write of 1 to status bit0 returns it to 0.
- R5: While the bus is held, a control write with the stop bit set and the start bit clear produces a STOP (SDA rises while SCL is high) within 3*HALF clock cycles, with no further byte sent and a pending data byte left in place (status bit2 stays 0).
- R6: While the bus is held, a control write with bits 0 to 3 set produces a repeated START, the address byte again, and then as many data bytes as the count register holds at that moment.
- R7: With the stop bit set and a nonzero loaded count, exactly that many data bytes are sent, then one STOP, then the core is idle (status bit3 = 0).
- R8: During byte transfer each SCL low phase and each SCL high phase lasts HALF clock cycles, and SDA changes while SCL stays high only for START and STOP.
- R9: A high SDA on the acknowledge pulse sets status bit1, sends a STOP at once and returns the core to idle. A write of 1 to status bit1 clears it.
- R10: If the data register is empty when the next data byte is due, SCL stays low with no clock pulses until the register is written, after which the transfer resumes.
- R11: A control write with bit0 clear releases both lines at once and clears the control bits, the flags and the pending data (status reads 0x04); the same values hold after reset.
- R12: A single control write with both start and stop bits while the bus is held gives a repeated START, the reloaded count of data bytes, and only then a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The two functions that can meet in one cycle are the repeated START and the STOP request: both are armed by the same control write while the bus is held. The bench provokes this with a single write that sets start and stop together, after having first rewritten the count register. It judges the outcome from the bus alone: a second START must appear, the address and the reloaded number of bytes must follow, and the one STOP must come only after the last of them, never right after the write.

// File: rtl/i2c_tx_sequencer.sv
module i2c_tx_sequencer #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [3:0] {
    IDLE, ST_A, ST_B, ST_C, B_LO, B_HI, A_LO, A_HI, WAITD, HOLD, SP_A, SP_B, SP_C
  } st_t;

  st_t st;
  logic [PW-1:0] ph;
  logic en_q, mst_q, tx_q, start_q, stop_q;
  logic [7:0] cnt_reg, txd, cnt, sh;
  logic [6:0] saddr;
  logic tx_full, hold_f, nack_f, is_addr;
  logic [2:0] bitn;

  wire adv     = (ph == PW'(HALF - 1));
  wire go      = en_q & mst_q & tx_q & start_q;
  wire wr_ctrl = reg_wr && reg_addr == 3'd0;
  wire wr_cnt  = reg_wr && reg_addr == 3'd1;
  wire wr_sa   = reg_wr && reg_addr == 3'd2;
  wire wr_tx   = reg_wr && reg_addr == 3'd3;
  wire wr_stat = reg_wr && reg_addr == 3'd4;
  wire last    = is_addr ? (cnt == 8'd0) : (cnt == 8'd1);
  wire untimed = (st == IDLE) || (st == HOLD) || (st == WAITD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0;
      en_q <= 1'b0; mst_q <= 1'b0; tx_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0;
      cnt_reg <= '0; txd <= '0; cnt <= '0; sh <= '0; saddr <= '0;
      tx_full <= 1'b0; hold_f <= 1'b0; nack_f <= 1'b0; is_addr <= 1'b0; bitn <= '0;
    end else if (wr_ctrl && !reg_wdata[0]) begin
      st <= IDLE; ph <= '0;
      en_q <= 1'b0; mst_q <= 1'b0; tx_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0;
      cnt <= '0; tx_full <= 1'b0; hold_f <= 1'b0; nack_f <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q <= reg_wdata[0]; mst_q <= reg_wdata[1]; tx_q <= reg_wdata[2];
        start_q <= reg_wdata[3]; stop_q <= reg_wdata[4];
      end
      if (wr_cnt) cnt_reg <= reg_wdata;
      if (wr_sa)  saddr <= reg_wdata[6:0];
      if (wr_stat && reg_wdata[0]) hold_f <= 1'b0;
      if (wr_stat && reg_wdata[1]) nack_f <= 1'b0;
      ph <= (untimed || adv) ? '0 : ph + 1'b1;

      case (st)
        IDLE:  if (go) st <= ST_B;
        HOLD:  if (go) st <= ST_A;
               else if (stop_q && cnt == 8'd0) st <= SP_A;
        ST_A:  if (adv) st <= ST_B;
        ST_B:  if (adv) begin st <= ST_C; cnt <= cnt_reg; start_q <= 1'b0; end
        ST_C:  if (adv) begin
                 st <= B_LO; sh <= {saddr, 1'b0}; is_addr <= 1'b1; bitn <= '0;
               end
        B_LO:  if (adv) st <= B_HI;
        B_HI:  if (adv) begin
                 bitn <= bitn + 3'd1; sh <= {sh[6:0], 1'b0};
                 st <= (bitn == 3'd7) ? A_LO : B_LO;
               end
        A_LO:  if (adv) st <= A_HI;
        A_HI:  if (adv) begin
                 if (!is_addr) cnt <= cnt - 8'd1;
                 if (sda_i) begin nack_f <= 1'b1; st <= SP_A; end
                 else if (last) begin
                   if (stop_q) st <= SP_A;
                   else begin hold_f <= 1'b1; st <= HOLD; end
                 end else st <= WAITD;
               end
        WAITD: if (tx_full) begin
                 sh <= txd; tx_full <= 1'b0; is_addr <= 1'b0; bitn <= '0; st <= B_LO;
               end
        SP_A:  if (adv) st <= SP_B;
        SP_B:  if (adv) st <= SP_C;
        SP_C:  if (adv) begin st <= IDLE; stop_q <= 1'b0; end
        default: st <= IDLE;
      endcase

      if (wr_tx) begin txd <= reg_wdata; tx_full <= 1'b1; end
    end
  end

  assign scl_oe = (st == ST_A) || (st == B_LO) || (st == A_LO) || (st == WAITD) ||
                  (st == HOLD) || (st == SP_A);
  assign sda_oe = (((st == B_LO) || (st == B_HI)) && !sh[7]) || (st == ST_C) ||
                  (st == SP_A) || (st == SP_B);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {3'b000, stop_q, start_q, tx_q, mst_q, en_q};
      3'd1:    reg_rdata = cnt_reg;
      3'd2:    reg_rdata = {1'b0, saddr};
      3'd3:    reg_rdata = txd;
      3'd4:    reg_rdata = {4'b0000, st != IDLE, !tx_full, nack_f, hold_f};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_tx_sequencer_chk.sv
module i2c_tx_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_hold,
  input logic       in_spa,
  input logic       in_stc,
  input logic       in_edge,
  input logic       in_ackhi,
  input logic       stop_req,
  input logic       start_req,
  input logic       hold_f,
  input logic       nack_f,
  input logic [7:0] cnt,
  input logic [7:0] count_reg
);
  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stc) |-> cnt == $past(count_reg));

  assert_cnt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !$rose(in_stc) && !$past(in_ackhi) |-> $stable(cnt));

  assert_hold_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_f) |-> in_hold && scl_oe);

  assert_stop_at_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold && en && stop_req && !start_req |=> in_spa || !en);

  assert_sda_quiet_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)) |-> in_edge);

  assert_nack_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_f) |-> in_spa);

  assert_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !scl_oe && !sda_oe);
endmodule

bind i2c_tx_sequencer i2c_tx_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .in_hold(st == HOLD), .in_spa(st == SP_A), .in_stc(st == ST_C),
  .in_edge(st == ST_C || st == SP_C), .in_ackhi(st == A_HI),
  .stop_req(stop_q), .start_req(start_q), .hold_f(hold_f), .nack_f(nack_f),
  .cnt(cnt), .count_reg(cnt_reg)
);

// File: tb/tb_i2c_tx_sequencer.sv
`timescale 1ns/1ps
module tb_i2c_tx_sequencer;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe;
  logic ack_drv = 1'b0, nack_mode = 1'b0;
  wire sda_line = !(sda_oe || ack_drv);

  i2c_tx_sequencer #(.HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_i(sda_line));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int n_start, n_stop, n_bytes, n_rise, bitm, run, min_hi, min_lo, exp_n;
  logic [7:0] log_b [0:63];
  logic [7:0] exp_b [0:63];
  logic [7:0] sreg;
  logic pscl = 1'b1, psda = 1'b1;

  always @(negedge clk) begin
    logic s, d;
    s = !scl_oe; d = sda_line;
    if (pscl && s && psda && !d) begin n_start++; bitm = 0; ack_drv = 1'b0; end
    if (pscl && s && !psda && d) n_stop++;
    if (!pscl && s) begin
      n_rise++;
      if (bitm < 8) begin
        sreg = {sreg[6:0], d}; bitm++;
        if (bitm == 8 && n_bytes < 64) begin log_b[n_bytes] = sreg; n_bytes++; end
      end else bitm = 0;
    end
    if (pscl && !s) ack_drv = (bitm == 8) && !nack_mode;
    if (s == pscl) run++;
    else begin
      if (pscl && run < min_hi) min_hi = run;
      if (!pscl && run < min_lo) min_lo = run;
      run = 1;
    end
    pscl = s; psda = d;
  end

  function automatic logic [7:0] addr_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic mon_clr();
    n_start = 0; n_stop = 0; n_bytes = 0; n_rise = 0; exp_n = 0;
    min_hi = 99999; min_lo = 99999; run = 1; bitm = 0; ack_drv = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    exp_b[exp_n] = v; exp_n++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stat(input int b, input bit v, input string tag);
    logic [7:0] s;
    bit hit = 0;
    for (int i = 0; i < 20000 && !hit; i++) begin
      rd(3'd4, s);
      if (s[b] == v) hit = 1;
    end
    if (!hit) chk(0, {tag, " status poll timeout"}, s[b], v);
  endtask

  task automatic cmp_log(input string tag);
    int bad = -1;
    for (int i = 0; i < exp_n && i < n_bytes; i++)
      if (bad < 0 && log_b[i] !== exp_b[i]) bad = i;
    chk(n_bytes == exp_n && bad < 0, tag,
        bad < 0 ? n_bytes : int'(log_b[bad]), bad < 0 ? exp_n : int'(exp_b[bad]));
  endtask

  task automatic feed(input logic [7:0] d, input string tag);
    wait_stat(2, 1'b1, tag); wr(3'd3, d); push(d);
  endtask

  task automatic xfer(input logic [6:0] a, input int n, input bit stp, input string tag);
    logic [7:0] d;
    wr(3'd4, 8'h03); wr(3'd2, {1'b0, a}); wr(3'd1, 8'(n));
    push(addr_byte(a));
    if (n > 0) begin d = 8'($urandom); wr(3'd3, d); push(d); end
    wr(3'd0, stp ? 8'h1F : 8'h0F);
    for (int i = 1; i < n; i++) feed(8'($urandom), tag);
    if (stp) wait_stat(3, 1'b0, tag); else wait_stat(0, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int snap, t;
    void'($urandom(32'd1234));
    mon_clr();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state (R11)
    rd(3'd4, s); chk(s == 8'h04, "R11 reset status", s, 8'h04);
    rd(3'd0, s); chk(s == 8'h00, "R11 reset control", s, 8'h00);
    chk(!scl_oe && !sda_oe, "R11 reset lines released", {scl_oe, sda_oe}, 0);

    // plain counted write with stop (R1, R7, R8)
    mon_clr();
    xfer(7'h5A, 2, 1'b1, "R7");
    cmp_log("R1 R7 address then two bytes");
    chk(n_start == 1, "R1 one START", n_start, 1);
    chk(n_stop == 1, "R7 one STOP at end", n_stop, 1);
    chk(min_hi == HALF, "R8 SCL high phase", min_hi, HALF);
    chk(min_lo == HALF, "R8 SCL low phase", min_lo, HALF);

    // count runs out without stop, then stop-only request (R4, R5, R3)
    mon_clr();
    xfer(7'h21, 1, 1'b0, "R4");
    rd(3'd4, s); chk(s[0] && s[3], "R4 hold flag and busy", s, 8'h09);
    chk(scl_oe == 1'b1, "R4 SCL parked low", scl_oe, 1);
    snap = n_rise;
    repeat (100) @(negedge clk);
    chk(n_stop == 0 && n_rise == snap, "R4 no STOP and no clocks while held", n_stop, 0);
    wr(3'd4, 8'h01);
    rd(3'd4, s); chk(s[0] == 1'b0, "R4 hold flag cleared by write", s[0], 0);
    wr(3'd1, 8'd3);
    wr(3'd3, 8'hC3);
    wr(3'd0, 8'h17);
    t = 0;
    while (n_stop == 0 && t < 100) begin @(negedge clk); t++; end
    chk(n_stop == 1 && t <= 3 * HALF, "R5 STOP issued promptly", t, 3 * HALF);
    wait_stat(3, 1'b0, "R5");
    chk(n_bytes == 2, "R5 no byte after stop request", n_bytes, 2);
    rd(3'd4, s); chk(s[2] == 1'b0, "R5 pending data kept", s[2], 0);

    // mid-transfer count rewrite, then repeated START reloads (R3, R6)
    mon_clr();
    wr(3'd4, 8'h03); wr(3'd2, 8'h33); wr(3'd1, 8'd1);
    push(addr_byte(7'h33));
    wr(3'd3, 8'hA1); push(8'hA1);
    wr(3'd0, 8'h0F);
    wait_stat(2, 1'b1, "R3");
    wr(3'd1, 8'd3);
    wait_stat(0, 1'b1, "R3");
    cmp_log("R3 count rewrite ignored until next START");
    wr(3'd4, 8'h01);
    push(addr_byte(7'h33));
    wr(3'd3, 8'hB2); push(8'hB2);
    wr(3'd0, 8'h0F);
    feed(8'hC3, "R6"); feed(8'hD4, "R6");
    wait_stat(0, 1'b1, "R6");
    chk(n_start == 2 && n_stop == 0, "R6 repeated START without STOP", n_start, 2);
    cmp_log("R6 reloaded count after repeated START");

    // start and stop requested in the same write while held (R12)
    wr(3'd4, 8'h01); wr(3'd1, 8'd2);
    push(addr_byte(7'h33));
    wr(3'd3, 8'hE5); push(8'hE5);
    wr(3'd0, 8'h1F);
    snap = n_stop;
    feed(8'hF6, "R12");
    chk(n_stop == snap, "R12 no STOP before last byte", n_stop, snap);
    wait_stat(3, 1'b0, "R12");
    chk(n_start == 3 && n_stop == 1, "R12 restart then one STOP", n_start * 16 + n_stop, 8'h31);
    cmp_log("R12 bytes of combined request");

    // no acknowledge (R9)
    mon_clr();
    nack_mode = 1'b1;
    wr(3'd4, 8'h03); wr(3'd2, 8'h10); wr(3'd1, 8'd2); wr(3'd3, 8'h55);
    wr(3'd0, 8'h1F);
    wait_stat(3, 1'b0, "R9");
    rd(3'd4, s); chk(s[1] == 1'b1, "R9 nack flag set", s[1], 1);
    chk(n_stop == 1 && n_bytes == 1, "R9 STOP right after address", n_bytes, 1);
    wr(3'd4, 8'h02);
    rd(3'd4, s); chk(s[1] == 1'b0, "R9 nack flag cleared", s[1], 0);
    nack_mode = 1'b0;

    // empty data register stalls the clock (R10)
    mon_clr();
    wr(3'd4, 8'h03); wr(3'd2, 8'h40); wr(3'd1, 8'd2);
    push(addr_byte(7'h40));
    wr(3'd3, 8'h11); push(8'h11);
    wr(3'd0, 8'h1F);
    wait_stat(2, 1'b1, "R10");
    repeat (150) @(negedge clk);
    snap = n_rise;
    repeat (200) @(negedge clk);
    chk(n_rise == snap && scl_oe == 1'b1, "R10 SCL held low while empty", n_rise - snap, 0);
    rd(3'd4, s); chk(s[3] && s[2], "R10 busy with empty register", s, 8'h0C);
    wr(3'd3, 8'h22); push(8'h22);
    wait_stat(3, 1'b0, "R10");
    cmp_log("R10 transfer resumes after refill");
    chk(n_stop == 1, "R10 STOP after resume", n_stop, 1);

    // disable mid-transfer (R11)
    mon_clr();
    wr(3'd1, 8'd4); wr(3'd3, 8'h99); wr(3'd0, 8'h1F);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h00);
    chk(!scl_oe && !sda_oe, "R11 lines released on disable", {scl_oe, sda_oe}, 0);
    rd(3'd4, s); chk(s == 8'h04, "R11 flags and data cleared", s, 8'h04);
    rd(3'd0, s); chk(s == 8'h00, "R11 control cleared", s, 8'h00);
    repeat (5) @(negedge clk);
    mon_clr();
    xfer(7'h2C, 1, 1'b1, "R11");
    cmp_log("R11 clean transfer after disable");

    // constrained random transfers (R2, R7)
    for (int k = 0; k < 25; k++) begin
      mon_clr();
      xfer(7'($urandom), int'($urandom_range(0, 3)), 1'b1, "R2");
      cmp_log("R2 random transfer bytes match count");
      chk(n_start == 1 && n_stop == 1, "R7 random transfer framing", n_start * 16 + n_stop, 8'h11);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule